// File: doc/BRIEF.md
# Debug Register Scan Chain

This block sits behind one JTAG test data register and gives a debug host access to a small bank of target debug registers. Every scan moves a 38-bit frame through the chain, least significant bit first. The first 32 bits shifted in are the data. The next 5 bits select a register. The last bit chooses between writing and reading. A write takes effect on the update strobe. A read is split across two scans: the scan that names the register ends with its update, and the capture strobe of the following scan loads that register into the data field so that it shifts out on TDO.

The bank holds a 6-bit debug control register with a monitor enable bit, a read-only 5-bit debug status view, an optional vector catch register and watchpoint storage. Each watchpoint unit has six 32-bit value and mask words. A bidirectional comms channel connects the host to a core-side port. Two flags track it: R means a host word is waiting for the core, and W means a core word is waiting for the host. Reading the comms data register through the chain pops the outbound word and clears W. A host can therefore end a burst of data reads by addressing comms control, which has no side effect. The TAP controller and the watchpoint comparators are outside this block. The strobes arrive as single-cycle enables in the system clock domain.

Top module: `dscan_top`

## Requirements
- R1: After reset, tdo, ctrl_out, vcatch_out, rx_full and tx_full are all 0, and the first capture returns debug control (0).
- R2: Frame bits [31:0] are data, [36:32] the register address and [37] the write flag (1 = write). Bit 0 is shifted in and out first. tdo changes only on capture or shift cycles.
- R3: A capture loads the register named by the most recent update into frame bits [31:0]. That register's contents shift out on tdo during the scan that follows the addressing scan.
- R4: Debug control at address 0x00 stores data bits [5:0] on a write, reads back zero-extended, and drives ctrl_out. Bit 4 is the monitor enable. It changes only on a write to 0x00.
- R5: Debug status at address 0x01 returns stat_in zero-extended. Writes to it have no effect.
- R6: Comms control at address 0x04 reads as {VERSION[3:0], 26 zero bits, W, R}, with VERSION defaulting to 5. Host writes to it are ignored.
- R7: A host write to comms data (0x05) stores the word on core_rdata and sets rx_full (R). A core_rd pulse clears rx_full.
- R8: A core_wr pulse stores core_wdata and sets tx_full (W). A capture that follows a read scan of 0x05 returns that word and clears tx_full, once per scan.
- R9: When core_rd falls in the same cycle as a host comms data write, rx_full stays 1. When core_wr falls in the same cycle as a popping capture, the old word is captured and tx_full stays 1 with the new word.
- R10: Watchpoint words at 0x08–0x0D (unit 0) and 0x10–0x15 (unit 1) are 32-bit read/write. Addresses 0x03, 0x06, 0x07, 0x0E, 0x0F and 0x16 and above read as zero.
- R11: Vector catch at 0x02 stores data bits [VC_W-1:0] (8 by default) and drives vcatch_out.
- R12: A capture that follows a write scan loads the addressed register but applies no side effect. A capture after a write to 0x05 returns the outbound word and leaves tx_full set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe of the data register |
| shf_en | input | 1 | Shift strobe, one bit per cycle |
| upd_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| stat_in | input | 5 | Debug status bits from the core |
| ctrl_out | output | 6 | Debug control register contents |
| vcatch_out | output | VC_W | Vector catch register contents |
| core_rd | input | 1 | Core takes the inbound word |
| core_rdata | output | 32 | Inbound word written by the host |
| rx_full | output | 1 | R flag: inbound word waiting |
| core_wr | input | 1 | Core posts an outbound word |
| core_wdata | input | 32 | Outbound word from the core |
| tx_full | output | 1 | W flag: outbound word waiting |

## Verification
The comms flags have two edges that can collide. A core write can fall in the same cycle as a capture that pops the outbound word, and a core read can fall in the same cycle as the update that writes a new inbound word. The bench pulses core_wr during the capture cycle of a popping scan. It expects the captured word to be the old one, tx_full to stay set, and the new word to appear on a later read. It also pulses core_rd during the update cycle of a comms data write and expects rx_full to stay 1 with the new word on core_rdata.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h01;
  localparam logic [ADDR_W-1:0] A_VCATCH = 5'h02;
  localparam logic [ADDR_W-1:0] A_CCTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CDATA  = 5'h05;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dscan_shift.sv
module dscan_shift
  import dscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output frame_t            frame,
  output logic              tdo
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)         sr <= '0;
    else if (cap_en) sr <= {{(FRAME_W-DATA_W){1'b0}}, cap_data};
    else if (shf_en) sr <= {tdi, sr[FRAME_W-1:1]};
  end

  assign frame = frame_t'(sr);
  assign tdo   = sr[0];
endmodule

// File: rtl/dscan_comms.sv
module dscan_comms
  import dscan_pkg::*;
#(
  parameter int VERSION = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_pop,
  input  logic              core_rd,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic [DATA_W-1:0] ctrl_word
);
  localparam int VER_W = 4;
  localparam int PAD_W = DATA_W - VER_W - 2;

  // inbound: a host write wins over a same-cycle core read
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
    end else if (host_wr) begin
      rx_data <= host_wdata;
      rx_full <= 1'b1;
    end else if (core_rd) begin
      rx_full <= 1'b0;
    end
  end

  // outbound: a core write wins over a same-cycle host pop
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data <= '0;
      tx_full <= 1'b0;
    end else if (core_wr) begin
      tx_data <= core_wdata;
      tx_full <= 1'b1;
    end else if (host_pop) begin
      tx_full <= 1'b0;
    end
  end

  assign ctrl_word = {VER_W'(VERSION), {PAD_W{1'b0}}, tx_full, rx_full};
endmodule

// File: rtl/dscan_regbank.sv
module dscan_regbank
  import dscan_pkg::*;
#(
  parameter int NUM_WP     = 2,
  parameter int CTRL_W     = 6,
  parameter int STAT_W     = 5,
  parameter int VC_W       = 8,
  parameter bit HAS_VCATCH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0] stat_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [VC_W-1:0]   vcatch_out
);
  localparam int WP_WORDS = 6;
  localparam int WP_N     = NUM_WP * WP_WORDS;
  localparam int WP_IW    = (WP_N > 1) ? $clog2(WP_N) : 1;

  function automatic logic wp_ok(input logic [ADDR_W-1:0] a);
    return (a[4:3] != 2'd0) && (int'(a[4:3]) <= NUM_WP) && (a[2:0] < 3'd6);
  endfunction

  function automatic logic [WP_IW-1:0] wp_idx(input logic [ADDR_W-1:0] a);
    return WP_IW'((int'(a[4:3]) - 1) * WP_WORDS + int'(a[2:0]));
  endfunction

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] wp_mem [WP_N];
  logic [DATA_W-1:0] vc_word;

  always_ff @(posedge clk) begin
    if (rst)                              ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL)  ctrl_q <= wr_data[CTRL_W-1:0];
  end

  // watchpoint words: plain write port, no reset, RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en && wp_ok(wr_addr)) wp_mem[wp_idx(wr_addr)] <= wr_data;
  end

  generate
    if (HAS_VCATCH) begin : g_vc
      logic [VC_W-1:0] vc_q;
      always_ff @(posedge clk) begin
        if (rst)                                vc_q <= '0;
        else if (wr_en && wr_addr == A_VCATCH)  vc_q <= wr_data[VC_W-1:0];
      end
      assign vcatch_out = vc_q;
      assign vc_word    = DATA_W'(vc_q);
    end else begin : g_no_vc
      assign vcatch_out = '0;
      assign vc_word    = '0;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (wp_ok(rd_addr))            rd_data = wp_mem[wp_idx(rd_addr)];
    else if (rd_addr == A_CTRL)    rd_data = DATA_W'(ctrl_q);
    else if (rd_addr == A_STAT)    rd_data = DATA_W'(stat_in);
    else if (rd_addr == A_VCATCH)  rd_data = vc_word;
  end

  assign ctrl_out = ctrl_q;
endmodule

// File: rtl/dscan_top.sv
module dscan_top
  import dscan_pkg::*;
#(
  parameter int NUM_WP     = 2,
  parameter int VERSION    = 5,
  parameter int VC_W       = 8,
  parameter bit HAS_VCATCH = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            shf_en,
  input  logic            upd_en,
  input  logic            tdi,
  output logic            tdo,
  input  logic [4:0]      stat_in,
  output logic [5:0]      ctrl_out,
  output logic [VC_W-1:0] vcatch_out,
  input  logic            core_rd,
  output logic [31:0]     core_rdata,
  output logic            rx_full,
  input  logic            core_wr,
  input  logic [31:0]     core_wdata,
  output logic            tx_full
);
  frame_t            frame;
  logic              upd_wr;
  logic [ADDR_W-1:0] upd_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_is_read;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] tx_data;
  logic [DATA_W-1:0] cc_word;
  logic              host_wr;
  logic              host_pop;

  assign upd_wr   = frame.wr;
  assign upd_addr = frame.addr;

  // address of the next capture, latched on every update
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr    <= A_CTRL;
      rd_is_read <= 1'b0;
    end else if (upd_en) begin
      rd_addr    <= upd_addr;
      rd_is_read <= ~upd_wr;
    end
  end

  assign host_wr  = upd_en & upd_wr & (upd_addr == A_CDATA);
  assign host_pop = cap_en & rd_is_read & (rd_addr == A_CDATA);

  always_comb begin
    if (rd_addr == A_CCTRL)      cap_data = cc_word;
    else if (rd_addr == A_CDATA) cap_data = tx_data;
    else                         cap_data = bank_rd;
  end

  dscan_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .shf_en   (shf_en),
    .tdi      (tdi),
    .cap_data (cap_data),
    .frame    (frame),
    .tdo      (tdo)
  );

  dscan_regbank #(
    .NUM_WP     (NUM_WP),
    .CTRL_W     (6),
    .STAT_W     (5),
    .VC_W       (VC_W),
    .HAS_VCATCH (HAS_VCATCH)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (upd_en & upd_wr),
    .wr_addr    (upd_addr),
    .wr_data    (frame.data),
    .rd_addr    (rd_addr),
    .stat_in    (stat_in),
    .rd_data    (bank_rd),
    .ctrl_out   (ctrl_out),
    .vcatch_out (vcatch_out)
  );

  dscan_comms #(
    .VERSION (VERSION)
  ) u_comms (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_wdata (frame.data),
    .host_pop   (host_pop),
    .core_rd    (core_rd),
    .core_wr    (core_wr),
    .core_wdata (core_wdata),
    .rx_data    (core_rdata),
    .rx_full    (rx_full),
    .tx_data    (tx_data),
    .tx_full    (tx_full),
    .ctrl_word  (cc_word)
  );
endmodule

// File: rtl/dscan_chk.sv
module dscan_chk (
  input logic       clk,
  input logic       rst,
  input logic       cap_en,
  input logic       shf_en,
  input logic       upd_en,
  input logic       tdo,
  input logic [5:0] ctrl_out,
  input logic       core_rd,
  input logic       core_wr,
  input logic       rx_full,
  input logic       tx_full,
  input logic       upd_wr,
  input logic [4:0] upd_addr,
  input logic [4:0] rd_addr,
  input logic       rd_is_read
);
  p_tdo_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !shf_en) |=> $stable(tdo));

  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(upd_en && upd_wr && upd_addr == 5'h00) |=> $stable(ctrl_out));

  p_host_wr_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_wr && upd_addr == 5'h05) |=> rx_full);

  p_core_rd_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (core_rd && !(upd_en && upd_wr && upd_addr == 5'h05)) |=> !rx_full);

  p_core_wr_sets_r8: assert property (@(posedge clk) disable iff (rst)
    core_wr |=> tx_full);

  p_pop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (cap_en && rd_is_read && rd_addr == 5'h05 && !core_wr) |=> !tx_full);

  p_w_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!core_wr && !(cap_en && rd_is_read && rd_addr == 5'h05)) |=> $stable(tx_full));
endmodule

bind dscan_top dscan_chk u_chk (.*);

// File: tb/dscan_top_bench.sv
module dscan_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [4:0]  stat_in = 5'h15;
  logic [5:0]  ctrl_out;
  logic [7:0]  vcatch_out;
  logic        core_rd = 1'b0, core_wr = 1'b0;
  logic [31:0] core_wdata = '0;
  logic [31:0] core_rdata;
  logic        rx_full, tx_full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dscan_top u_dscan_top (
    .clk(clk), .rst(rst), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en),
    .tdi(tdi), .tdo(tdo), .stat_in(stat_in), .ctrl_out(ctrl_out),
    .vcatch_out(vcatch_out), .core_rd(core_rd), .core_rdata(core_rdata),
    .rx_full(rx_full), .core_wr(core_wr), .core_wdata(core_wdata), .tx_full(tx_full)
  );

  // {write, addr, wdata, expected capture of this scan}
  localparam logic [69:0] VEC [14] = '{
    {1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0000_0000}, // R1 first capture
    {1'b0, 5'h00, 32'h0,         32'h0000_003F}, // R4 width, R12
    {1'b0, 5'h01, 32'h0,         32'h0000_003F}, // R3
    {1'b1, 5'h01, 32'hFFFF_FFFF, 32'h0000_0015}, // R5
    {1'b0, 5'h01, 32'h0,         32'h0000_0015}, // R5 write ignored
    {1'b1, 5'h08, 32'hA5A5_0001, 32'h0000_0015},
    {1'b1, 5'h15, 32'h1234_5678, 32'hA5A5_0001}, // R10
    {1'b0, 5'h08, 32'h0,         32'h1234_5678}, // R10
    {1'b0, 5'h15, 32'h0,         32'hA5A5_0001}, // R10
    {1'b0, 5'h06, 32'h0,         32'h1234_5678}, // R10
    {1'b1, 5'h02, 32'hFFFF_FFFF, 32'h0000_0000}, // R10 unmapped
    {1'b0, 5'h04, 32'h0,         32'h0000_00FF}, // R11
    {1'b0, 5'h00, 32'h0,         32'h5000_0000}, // R6
    {1'b0, 5'h00, 32'h0,         32'h0000_003F}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  task automatic scan(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      input logic rd_at_upd, input logic cw_at_cap,
                      input logic [31:0] cw_d, output logic [31:0] got);
    logic [37:0] f;
    f = {wr, a, d};
    got = '0;
    @(negedge clk);
    cap_en = 1'b1; core_wr = cw_at_cap; core_wdata = cw_d;
    @(negedge clk);
    cap_en = 1'b0; core_wr = 1'b0;
    for (int i = 0; i < 38; i++) begin
      if (i < 32) got[i] = tdo;
      tdi = f[i];
      shf_en = 1'b1;
      @(negedge clk);
    end
    shf_en = 1'b0;
    upd_en = 1'b1; core_rd = rd_at_upd;
    @(negedge clk);
    upd_en = 1'b0; core_rd = 1'b0;
  endtask

  task automatic pulse_core(input logic rd, input logic wr, input logic [31:0] d);
    @(negedge clk);
    core_rd = rd; core_wr = wr; core_wdata = d;
    @(negedge clk);
    core_rd = 1'b0; core_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tdo", 32'(tdo), 32'h0);
    chk("R1 ctrl", 32'(ctrl_out), 32'h0);
    chk("R1 vcatch", 32'(vcatch_out), 32'h0);
    chk("R1 flags", {30'h0, tx_full, rx_full}, 32'h0);

    // R2 R3 R5 R10 R11 table walk
    for (int i = 0; i < 14; i++) begin
      scan(VEC[i][69], VEC[i][68:64], VEC[i][63:32], 1'b0, 1'b0, 32'h0, got);
      chk("R2 R3 R5 R10 R11 table", got, VEC[i][31:0]);
    end
    chk("R11 vcatch_out", 32'(vcatch_out), 32'hFF);

    // R4 monitor enable bit
    scan(1'b1, 5'h00, 32'h0000_0010, 1'b0, 1'b0, 32'h0, got);
    chk("R4 ctrl_out", 32'(ctrl_out), 32'h10);

    // R7 host to core
    scan(1'b1, 5'h05, 32'hCAFE_0001, 1'b0, 1'b0, 32'h0, got);
    chk("R7 rx_full set", 32'(rx_full), 32'h1);
    chk("R7 core_rdata", core_rdata, 32'hCAFE_0001);
    pulse_core(1'b1, 1'b0, 32'h0);
    chk("R7 rx_full clear", 32'(rx_full), 32'h0);

    // R9 core read in same cycle as host write
    scan(1'b1, 5'h05, 32'hBEEF_0002, 1'b1, 1'b0, 32'h0, got);
    chk("R9 rx_full kept", 32'(rx_full), 32'h1);
    chk("R9 core_rdata", core_rdata, 32'hBEEF_0002);
    pulse_core(1'b1, 1'b0, 32'h0);

    // R8 core to host, R12 capture after write has no side effect
    pulse_core(1'b0, 1'b1, 32'h0D0D_0002);
    chk("R8 tx_full set", 32'(tx_full), 32'h1);
    scan(1'b0, 5'h05, 32'h0, 1'b0, 1'b0, 32'h0, got);
    chk("R12 capture after write", got, 32'h0D0D_0002);
    chk("R12 tx_full kept", 32'(tx_full), 32'h1);
    scan(1'b0, 5'h04, 32'h0, 1'b0, 1'b0, 32'h0, got);
    chk("R8 popped word", got, 32'h0D0D_0002);
    chk("R8 tx_full clear", 32'(tx_full), 32'h0);

    // R6 comms control read and ignored write
    scan(1'b1, 5'h04, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, got);
    chk("R6 comms ctrl", got, 32'h5000_0000);
    scan(1'b0, 5'h00, 32'h0, 1'b0, 1'b0, 32'h0, got);
    chk("R6 write ignored", got, 32'h5000_0000);

    // R9 core write in same cycle as a popping capture
    pulse_core(1'b0, 1'b1, 32'h0000_0033);
    scan(1'b0, 5'h05, 32'h0, 1'b0, 1'b0, 32'h0, got);
    chk("R4 ctrl readback", got, 32'h10);
    scan(1'b0, 5'h04, 32'h0, 1'b0, 1'b1, 32'h0000_0044, got);
    chk("R9 old word captured", got, 32'h0000_0033);
    chk("R9 tx_full kept", 32'(tx_full), 32'h1);
    scan(1'b0, 5'h05, 32'h0, 1'b0, 1'b0, 32'h0, got);
    chk("R9 W in comms ctrl", got, 32'h5000_0002);
    scan(1'b0, 5'h04, 32'h0, 1'b0, 1'b0, 32'h0, got);
    chk("R9 new word", got, 32'h0000_0044);
    chk("R8 tx_full clear again", 32'(tx_full), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule